// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter that a CPU programs through a small byte-wide register port. It counts either a prescaled clock enable or falling edges on an external count pin. A second external pin, the trigger, can make the block take a snapshot of the count or reload the count. Any change on either pin only takes effect after two synchronizer stages. A sticky flag records each overflow and another records each trigger event, and the interrupt request is raised whenever either flag is set.

When either serial clock select bit is set, the block works as a baud-rate generator. Its overflows become the receive and/or transmit tick of a serial port. Reload on overflow is then forced, and the trigger pin and the overflow flag are both turned off. A direction whose select bit is clear passes an alternate tick, supplied from another timer, through to its output instead.

Top module: `cr_timer`

## Requirements
- R1: After a synchronous reset the control byte, the count and the reload/capture register are all zero, and `irq`, `rx_tick` and `tx_tick` are low.
- R2: Register map on `bus_addr`: 0 is control, 1 and 2 are count low and high, 3 and 4 are reload/capture low and high. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is registered and shows the register addressed one cycle earlier. The control bits, from bit 7 down to bit 0, are: overflow flag, trigger flag, rx select, tx select, trigger enable, run, pin-count mode, capture mode.
- R3: With run=1 and pin-count mode=0, the count goes up by one on each cycle where `prescale_tick` is high. With run=0 the count holds.
- R4: With pin-count mode=1, the count goes up once for each falling edge of `cnt_pin`, and `prescale_tick` has no effect.
- R5: In reload mode (capture mode=0, or either select bit set), an increment at 0xFFFF loads the count from the reload register at the same edge. When neither select bit is set, this also sets the overflow flag (bit 7).
- R6: With capture mode=1, trigger enable=1 and no select bit set, a falling edge on `trig_pin` copies the count into the capture register and sets the trigger flag (bit 6). The count is not changed. An overflow in this mode wraps the count to 0 and sets bit 7.
- R7: With capture mode=0 and trigger enable=1, a falling edge on `trig_pin` loads the count from the reload register and sets bit 6, even when run=0.
- R8: With trigger enable=0, trigger-pin edges leave the count, the capture register and bit 6 unchanged.
- R9: While rx select (bit 5) or tx select (bit 4) is 1, overflows do not set bit 7, the capture mode bit is ignored (the count still reloads), and the trigger pin is ignored.
- R10: `rx_tick` is a registered copy of this timer's overflow pulse when bit 5 is 1, and of `alt_rx_tick` when bit 5 is 0. `tx_tick` works the same way with bit 4 and `alt_tx_tick`. Both are delayed by one cycle.
- R11: Bits 7 and 6 are sticky. Only a software write of 0 clears them. If a hardware set and a software write land in the same cycle, the set wins.
- R12: `irq` is high exactly when bit 7 or bit 6 is set, and changes in the same cycle as the flags.
- R13: A software write to a count byte takes priority over a hardware increment or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| prescale_tick | input | 1 | Count enable in timer mode |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| alt_rx_tick | input | 1 | Receive tick from another timer |
| alt_tx_tick | input | 1 | Transmit tick from another timer |
| irq | output | 1 | Interrupt request |
| rx_tick | output | 1 | Receive baud tick |
| tx_tick | output | 1 | Transmit baud tick |

## Verification
Two things can land in the same cycle: the hardware overflow that sets the flag, and a software write to the control byte that clears it. The bench provokes this by loading the count with 0xFFFF. It then raises `prescale_tick` in exactly the cycle that carries a control write of 0x04. Reading back 0x84 shows that the flag set wins, and the count is also checked to have reloaded in that cycle. In the same way, a count-byte write is placed in a cycle that also carries an increment, and the written value must be the one that survives.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

  // Control byte; the bit order is the software-visible layout.
  typedef struct packed {
    logic ovf;       // 7 overflow flag
    logic ext;       // 6 trigger flag
    logic rx_sel;    // 5 receive tick from this timer
    logic tx_sel;    // 4 transmit tick from this timer
    logic ext_en;    // 3 trigger pin enable
    logic run;       // 2 count enable
    logic cnt_mode;  // 1 count pin edges instead of prescale tick
    logic cap_mode;  // 0 capture instead of reload on trigger
  } ctrl_t;

  localparam int unsigned CTRL_ADDR = 0;

endpackage

// File: rtl/cr_pin_sync.sv
module cr_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {(STAGES+1){IDLE}};
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/cr_ctrl_reg.sv
module cr_ctrl_reg
  import cr_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       ovf_set,
  input  logic       ext_set,
  output ctrl_t      ctrl,
  output logic       irq
);
  ctrl_t nxt;

  always_comb begin
    nxt = ctrl;
    if (wr_en)   nxt = ctrl_t'(wdata);
    if (ovf_set) nxt.ovf = 1'b1;   // hardware set beats a same-cycle write
    if (ext_set) nxt.ext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      irq  <= 1'b0;
    end else begin
      ctrl <= nxt;
      irq  <= nxt.ovf | nxt.ext;
    end
  end
endmodule

// File: rtl/cr_count_core.sv
module cr_count_core #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             reload_mode,
  input  logic             trig_act,
  input  logic [BYTES-1:0] cnt_byte_we,
  input  logic [BYTES-1:0] cap_byte_we,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap,
  output logic             ovf
);
  logic             at_top;
  logic             do_load;
  logic             do_capt;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cap_nxt;

  assign at_top  = &count;
  assign ovf     = inc & at_top;
  assign do_load = reload_mode & (ovf | trig_act);
  assign do_capt = ~reload_mode & trig_act;

  always_comb begin
    if (do_load)  cnt_base = cap;
    else if (inc) cnt_base = count + 1'b1;
    else          cnt_base = count;
    cnt_nxt = cnt_base;
    for (int b = 0; b < BYTES; b++)
      if (cnt_byte_we[b]) cnt_nxt[b*8 +: 8] = wdata;
  end

  always_comb begin
    cap_nxt = cap;
    for (int b = 0; b < BYTES; b++)
      if (cap_byte_we[b]) cap_nxt[b*8 +: 8] = wdata;
    if (do_capt) cap_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      cap   <= '0;
    end else begin
      count <= cnt_nxt;
      cap   <= cap_nxt;
    end
  end
endmodule

// File: rtl/cr_timer.sv
module cr_timer
  import cr_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BYTES  = CNT_W / 8,
  localparam int unsigned NREG   = 1 + 2 * BYTES,
  localparam int unsigned ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              prescale_tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              alt_rx_tick,
  input  logic              alt_tx_tick,
  output logic              irq,
  output logic              rx_tick,
  output logic              tx_tick
);
  localparam int unsigned NPIN = 2;

  logic [NPIN-1:0]  pin_vec;
  logic [NPIN-1:0]  fall_vec;
  logic             cnt_fall;
  logic             trig_fall;
  ctrl_t            ctrl;
  logic             ctrl_wr;
  logic [BYTES-1:0] cnt_byte_we;
  logic [BYTES-1:0] cap_byte_we;
  logic             cnt_wr;
  logic             baud;
  logic             reload_mode;
  logic             trig_act;
  logic             inc;
  logic             ovf_pulse;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap;
  logic [7:0]       rd_mux;

  assign pin_vec = {trig_pin, cnt_pin};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    cr_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (pin_vec[p]),
      .fall (fall_vec[p])
    );
  end

  assign cnt_fall  = fall_vec[0];
  assign trig_fall = fall_vec[1];

  // Address decode
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      cnt_byte_we[b] = bus_wr && (bus_addr == ADDR_W'(1 + b));
      cap_byte_we[b] = bus_wr && (bus_addr == ADDR_W'(1 + BYTES + b));
    end
  end
  assign cnt_wr = |cnt_byte_we;

  // Mode resolution
  assign baud        = ctrl.rx_sel | ctrl.tx_sel;
  assign reload_mode = baud | ~ctrl.cap_mode;
  assign trig_act    = trig_fall & ctrl.ext_en & ~baud;
  assign inc         = ctrl.run & (ctrl.cnt_mode ? cnt_fall : prescale_tick);

  cr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .inc         (inc),
    .reload_mode (reload_mode),
    .trig_act    (trig_act),
    .cnt_byte_we (cnt_byte_we),
    .cap_byte_we (cap_byte_we),
    .wdata       (bus_wdata),
    .count       (count),
    .cap         (cap),
    .ovf         (ovf_pulse)
  );

  cr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctrl_wr),
    .wdata   (bus_wdata),
    .ovf_set (ovf_pulse & ~baud),
    .ext_set (trig_act),
    .ctrl    (ctrl),
    .irq     (irq)
  );

  // Read path, registered
  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) rd_mux = ctrl;
    for (int b = 0; b < BYTES; b++) begin
      if (bus_addr == ADDR_W'(1 + b))         rd_mux = count[b*8 +: 8];
      if (bus_addr == ADDR_W'(1 + BYTES + b)) rd_mux = cap[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      rx_tick   <= 1'b0;
      tx_tick   <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      rx_tick   <= ctrl.rx_sel ? ovf_pulse : alt_rx_tick;
      tx_tick   <= ctrl.tx_sel ? ovf_pulse : alt_tx_tick;
    end
  end
endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       ctrl_b,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap,
  input logic             irq,
  input logic             rx_tick,
  input logic             tx_tick,
  input logic             ovf_pulse,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic             trig_act,
  input logic             baud,
  input logic             reload_mode
);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_b[7] && !ctrl_wr) |=> ctrl_b[7]);

  // R11
  ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_b[6] && !ctrl_wr) |=> ctrl_b[6]);

  // R9
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (baud && !ctrl_wr) |=> !$rose(ctrl_b[7]));

  // R8
  ext_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_b[3] && !ctrl_wr) |=> !$rose(ctrl_b[6]));

  // R12
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_b[7] | ctrl_b[6]));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && reload_mode && !cnt_wr) |=> count == $past(cap));

  // R10
  rx_route_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_b[5] |=> rx_tick == $past(ovf_pulse));

  // R10
  tx_route_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_b[4] |=> tx_tick == $past(ovf_pulse));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_b[2] && !cnt_wr && !trig_act) |=> $stable(count));
endmodule

bind cr_timer cr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_b      (ctrl),
  .count       (count),
  .cap         (cap),
  .irq         (irq),
  .rx_tick     (rx_tick),
  .tx_tick     (tx_tick),
  .ovf_pulse   (ovf_pulse),
  .ctrl_wr     (ctrl_wr),
  .cnt_wr      (cnt_wr),
  .trig_act    (trig_act),
  .baud        (baud),
  .reload_mode (reload_mode)
);

// File: tb/cr_timer_tb.sv
module cr_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       prescale_tick = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       alt_rx_tick = 1'b0;
  logic       alt_tx_tick = 1'b0;
  logic       irq, rx_tick, tx_tick;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  cr_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prescale_tick(prescale_tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .alt_rx_tick(alt_rx_tick), .alt_tx_tick(alt_tx_tick),
    .irq(irq), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  // {rx_sel, tx_sel, alt_rx, alt_tx, exp_rx, exp_tx}, timer stopped
  localparam logic [5:0] VEC [8] = '{
    6'b00_11_11, 6'b00_10_10, 6'b10_11_01, 6'b01_11_10,
    6'b11_11_00, 6'b01_01_00, 6'b10_10_00, 6'b00_01_01
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    prescale_tick = 1'b1;
    repeat (n) @(negedge clk);
    prescale_tick = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk);
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #250000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 ticks", {rx_tick, tx_tick}, 0);
    rd(0, b);    check("R1 ctrl", b, 8'h00);
    rd16(1, v);  check("R1 count", v, 0);
    rd16(3, v);  check("R1 cap", v, 0);

    // R10 tick routing table
    foreach (VEC[i]) begin
      wr(0, {2'b00, VEC[i][5:4], 4'h0});
      @(negedge clk);
      alt_rx_tick = VEC[i][3]; alt_tx_tick = VEC[i][2];
      @(negedge clk);
      alt_rx_tick = 1'b0; alt_tx_tick = 1'b0;
      check($sformatf("R10 vec%0d", i), {rx_tick, tx_tick}, VEC[i][1:0]);
    end
    wr(0, 8'h00);

    // R2 register access
    wr16(1, 16'h1234); rd16(1, v); check("R2 count rw", v, 16'h1234);
    wr16(3, 16'hABCD); rd16(3, v); check("R2 cap rw", v, 16'hABCD);

    // R3 timer counting and hold
    wr(0, 8'h04); wr16(1, 16'h0010);
    tick_n(5);
    rd16(1, v); check("R3 count 5 ticks", v, 16'h0015);
    wr(0, 8'h00);
    tick_n(3);
    rd16(1, v); check("R3 hold run=0", v, 16'h0015);

    // R5 overflow reload and flag, R12 irq
    wr16(3, 16'h8000); wr16(1, 16'hFFFE); wr(0, 8'h04);
    tick_n(2);
    rd16(1, v); check("R5 reload value", v, 16'h8000);
    rd(0, b);   check("R5 ovf flag", b, 8'h84);
    check("R12 irq on ovf", irq, 1);

    // R11 software clear
    wr(0, 8'h04);
    rd(0, b); check("R11 clear", b, 8'h04);
    check("R12 irq cleared", irq, 0);

    // R11 hardware set against same-cycle clear
    wr16(1, 16'hFFFF);
    @(negedge clk);
    prescale_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h04;
    @(negedge clk);
    prescale_tick = 1'b0; bus_wr = 1'b0;
    rd(0, b);   check("R11 set wins", b, 8'h84);
    rd16(1, v); check("R5 reload in collision", v, 16'h8000);

    // R13 software count write against same-cycle increment
    wr(0, 8'h04); wr16(1, 16'h0100);
    @(negedge clk);
    prescale_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h77;
    @(negedge clk);
    prescale_tick = 1'b0; bus_wr = 1'b0;
    rd16(1, v); check("R13 write wins", v, 16'h0177);

    // R4 pin counting, prescale tick held high but ignored
    wr(0, 8'h06); wr16(1, 16'h0000);
    @(negedge clk); prescale_tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
    end
    prescale_tick = 1'b0;
    rd16(1, v); check("R4 pin edges", v, 16'h0003);

    // R7 trigger reload while stopped
    wr(0, 8'h08); wr16(1, 16'h0100); wr16(3, 16'h5555);
    trig_pulse();
    rd16(1, v); check("R7 trig reload", v, 16'h5555);
    rd(0, b);   check("R7 ext flag", b, 8'h48);
    check("R12 irq on ext", irq, 1);

    // R8 trigger disabled
    wr(0, 8'h00); wr16(1, 16'h0100);
    trig_pulse();
    rd16(1, v); check("R8 count kept", v, 16'h0100);
    rd(0, b);   check("R8 no flag", b, 8'h00);

    // R6 capture
    wr(0, 8'h09); wr16(1, 16'h2222); wr16(3, 16'h0000);
    trig_pulse();
    rd16(3, v); check("R6 captured", v, 16'h2222);
    rd16(1, v); check("R6 count unchanged", v, 16'h2222);
    rd(0, b);   check("R6 ext flag", b, 8'h49);
    wr(0, 8'h0D); wr16(1, 16'hFFFF);
    tick_n(1);
    rd16(1, v); check("R6 wrap to zero", v, 16'h0000);
    rd(0, b);   check("R6 ovf flag", b, 8'h8D);

    // R9 baud mode: forced reload, no flag, trigger ignored
    wr(0, 8'h2D); wr16(3, 16'h1000); wr16(1, 16'hFFFF);
    @(negedge clk); prescale_tick = 1'b1;
    @(negedge clk); prescale_tick = 1'b0;
    check("R10 rx ovf tick", {rx_tick, tx_tick}, 2'b10);
    rd16(1, v); check("R9 forced reload", v, 16'h1000);
    rd(0, b);   check("R9 no ovf flag", b, 8'h2D);
    trig_pulse();
    rd16(1, v); check("R9 trig ignored count", v, 16'h1000);
    rd16(3, v); check("R9 trig ignored cap", v, 16'h1000);
    rd(0, b);   check("R9 trig no flag", b, 8'h2D);

    finish_run();
  end
endmodule